// File: doc/BRIEF.md
# Scrolled Tile-Map Address Generator

This block produces the video-memory read addresses that a tile-based display pipeline needs to fetch one scanline. A one-cycle `start` pulse captures the current line number, the scroll offsets, the window position and the layer control byte. The block then walks the scanline's 8-pixel tile columns in order. For each column it issues one read of the tile-map byte, takes the tile index that memory returns, and issues the two plane-byte reads for the tile row that this scanline crosses.

The background layer is covered first. Its tile grid is 32 by 32 entries and wraps on each axis separately, and the scroll values pick the starting tile and the fine row. When the window layer is switched on and the line has reached the window's top edge, the window columns follow, starting at map column 0. Every request holds its address until the memory side acknowledges it. A tag on each request marks the layer and the read type, so downstream pixel logic can steer the returned bytes.

Top module: `tmap_addr_gen`

## Requirements
- R1: Each tile column issues exactly three reads in this order: map byte, low plane byte, high plane byte. `rd_req` and `rd_addr` stay stable until the cycle in which `rd_ack` is high. The index on `rd_data` is taken in the map read's acknowledge cycle.
- R2: The background covers 22 columns. Column c reads map column ((scx >> 3) + c) mod 32, so the map column wraps from 31 to 0.
- R3: The background map row is ((line + scy) mod 256) >> 3, and the fine row within the tile is (line + scy) & 7.
- R4: A map address equals base + row*32 + column. The base is 0x1800 when the layer's map-select control bit is 0 and 0x1C00 when it is 1. The background uses ctrl bit 3 and the window uses ctrl bit 6.
- R5: When ctrl bit 4 is 0, a returned index below 128 is used as index + 256; otherwise the index is used as given. The low plane address is index*16 + fine_row*2, and the high plane address is that value + 1.
- R6: Window columns are read only when ctrl bit 5 is 1 and line >= wy. They follow the last background column.
- R7: The window's map row is ((line - wy) mod 256) >> 3 wrapped to 32 rows, and its fine row is (line - wy) & 7. Window column c reads map column c. The column count is ((175 - wx) >> 3) + 1 when wx <= 175, and zero when wx > 175.
- R8: `rd_layer` is 0 for background reads and 1 for window reads.
- R9: After reset, and after the last read of a line, `rd_req` is low. A `start` pulse, or a change of any configuration input, while a line is in progress has no effect on that line's reads.
- R10: `rd_kind` encodes the read type: 0 for the map byte, 1 for the low plane byte, 2 for the high plane byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one scanline; ignored while a line is active |
| line | input | 8 | Current scanline number |
| scx | input | 8 | Horizontal scroll of the background |
| scy | input | 8 | Vertical scroll of the background |
| wx | input | 8 | Window left edge plus 7 |
| wy | input | 8 | Window top line |
| ctrl | input | 8 | Layer control (bits 3, 4, 5, 6 used) |
| rd_req | output | 1 | Read request valid |
| rd_kind | output | 2 | Read type tag |
| rd_layer | output | 1 | Layer tag |
| rd_addr | output | 13 | Video-memory byte address |
| rd_ack | input | 1 | Memory accepts the current request |
| rd_data | input | 8 | Tile index returned for a map read |

## Verification
On every cycle, the assertions check the handshake: the address and the tag hold until acknowledged, a low-plane read follows each acknowledged map read, and the high-plane address is the low-plane address plus one. They also check that map addresses fall in the upper map region and data addresses fall below it, and that the window layer is entered only after the last background column. The exact address values can only be shown by the bench's scenarios. These values depend on scroll wraparound, fine-row arithmetic, signed index remapping, base selection and the window column count. The bench's scenarios also cover the case where the window is suppressed by line, by position or by the enable bit, and the case where a second `start` arrives mid-line.

// File: rtl/tmap_pkg.sv
package tmap_pkg;

  typedef enum logic [1:0] {
    KIND_MAP = 2'd0,
    KIND_LO  = 2'd1,
    KIND_HI  = 2'd2
  } rd_kind_e;

  typedef enum logic {
    LYR_BG  = 1'b0,
    LYR_WIN = 1'b1
  } layer_e;

  // control byte bit positions
  localparam int CTL_BG_MAP_SEL  = 3;
  localparam int CTL_IDX_UNSGN   = 4;
  localparam int CTL_WIN_EN      = 5;
  localparam int CTL_WIN_MAP_SEL = 6;

endpackage

// File: rtl/tmap_scroll_calc.sv
module tmap_scroll_calc #(
  parameter int COORD_W   = 8,
  parameter int MAP_BITS  = 5,
  parameter int FINE_BITS = 3,
  parameter int SPAN      = 168,
  parameter int WIN_X_OFS = 7,
  parameter int COL_W     = 5
) (
  input  logic [COORD_W-1:0]   line,
  input  logic [COORD_W-1:0]   scx,
  input  logic [COORD_W-1:0]   scy,
  input  logic [COORD_W-1:0]   wx,
  input  logic [COORD_W-1:0]   wy,
  input  logic                 win_en,
  output logic [MAP_BITS-1:0]  bg_tx0,
  output logic [MAP_BITS-1:0]  bg_ty,
  output logic [FINE_BITS-1:0] bg_row,
  output logic [MAP_BITS-1:0]  win_ty,
  output logic [FINE_BITS-1:0] win_row,
  output logic [COL_W-1:0]     win_cols,
  output logic                 win_on
);

  localparam logic [COORD_W:0] WIN_LIMIT = (COORD_W+1)'(SPAN + WIN_X_OFS);

  logic [COORD_W-1:0] bg_y;
  logic [COORD_W-1:0] win_y;
  logic [COORD_W:0]   wx_ext;
  logic [COORD_W:0]   cols_raw;

  always_comb begin
    bg_y     = line + scy;
    win_y    = line - wy;
    wx_ext   = {1'b0, wx};
    bg_tx0   = scx[FINE_BITS +: MAP_BITS];
    bg_ty    = bg_y[FINE_BITS +: MAP_BITS];
    bg_row   = bg_y[FINE_BITS-1:0];
    win_ty   = win_y[FINE_BITS +: MAP_BITS];
    win_row  = win_y[FINE_BITS-1:0];
    cols_raw = ((WIN_LIMIT - wx_ext) >> FINE_BITS) + (COORD_W+1)'(1);
    win_cols = cols_raw[COL_W-1:0];
    win_on   = win_en && (line >= wy) && (wx_ext <= WIN_LIMIT);
  end

endmodule

// File: rtl/tmap_col_seq.sv
module tmap_col_seq
  import tmap_pkg::*;
#(
  parameter int COL_W   = 5,
  parameter int BG_COLS = 22
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start,
  input  logic             rd_ack,
  input  logic             win_on,
  input  logic [COL_W-1:0] win_cols,
  output logic             busy,
  output rd_kind_e         kind,
  output layer_e           layer,
  output logic [COL_W-1:0] col,
  output logic             load,
  output logic             map_ack
);

  localparam logic [COL_W-1:0] BG_LAST = COL_W'(BG_COLS - 1);

  logic             busy_q, busy_n;
  rd_kind_e         kind_q, kind_n;
  layer_e           layer_q, layer_n;
  logic [COL_W-1:0] col_q, col_n;
  logic [COL_W-1:0] last_col;
  logic             step;

  always_comb begin
    last_col = (layer_q == LYR_BG) ? BG_LAST : (win_cols - COL_W'(1));
    load     = !busy_q && start;
    map_ack  = busy_q && rd_ack && (kind_q == KIND_MAP);
    step     = load || (busy_q && rd_ack);
    busy_n   = busy_q;
    kind_n   = kind_q;
    layer_n  = layer_q;
    col_n    = col_q;
    if (!busy_q) begin
      if (start) begin
        busy_n  = 1'b1;
        kind_n  = KIND_MAP;
        layer_n = LYR_BG;
        col_n   = '0;
      end
    end else if (rd_ack) begin
      case (kind_q)
        KIND_MAP: kind_n = KIND_LO;
        KIND_LO:  kind_n = KIND_HI;
        default: begin
          kind_n = KIND_MAP;
          if (col_q != last_col) begin
            col_n = col_q + COL_W'(1);
          end else if (layer_q == LYR_BG && win_on) begin
            layer_n = LYR_WIN;
            col_n   = '0;
          end else begin
            busy_n  = 1'b0;
            layer_n = LYR_BG;
            col_n   = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      kind_q  <= KIND_MAP;
      layer_q <= LYR_BG;
      col_q   <= '0;
    end else if (step) begin
      busy_q  <= busy_n;
      kind_q  <= kind_n;
      layer_q <= layer_n;
      col_q   <= col_n;
    end
  end

  assign busy  = busy_q;
  assign kind  = kind_q;
  assign layer = layer_q;
  assign col   = col_q;

  // R1: an acknowledged map read is followed by the low plane read of the same column
  a_r1_lo_after_map: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && rd_ack && kind_q == KIND_MAP) |=>
      (busy_q && kind_q == KIND_LO && $stable(col_q) && $stable(layer_q)));

  // R9: nothing moves while a request waits for its acknowledge, even if start arrives
  a_r9_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && !rd_ack) |=> (busy_q && $stable(col_q) && $stable(layer_q) && $stable(kind_q)));

  // R6: the window layer begins only right after an acknowledged background high-plane read
  a_r6_window_after_bg: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(layer_q == LYR_WIN) |-> ($past(rd_ack && kind_q == KIND_HI && layer_q == LYR_BG) && win_on));

endmodule

// File: rtl/tmap_addr_mux.sv
module tmap_addr_mux
  import tmap_pkg::*;
#(
  parameter int                 ADDR_W      = 13,
  parameter int                 MAP_BITS    = 5,
  parameter int                 FINE_BITS   = 3,
  parameter int                 IDX_W       = 9,
  parameter int                 COL_W       = 5,
  parameter logic [ADDR_W-1:0]  MAP_BASE_LO = 13'h1800,
  parameter logic [ADDR_W-1:0]  MAP_BASE_HI = 13'h1C00
) (
  input  rd_kind_e             kind,
  input  layer_e               layer,
  input  logic [COL_W-1:0]     col,
  input  logic [MAP_BITS-1:0]  bg_tx0,
  input  logic [MAP_BITS-1:0]  bg_ty,
  input  logic [FINE_BITS-1:0] bg_row,
  input  logic [MAP_BITS-1:0]  win_ty,
  input  logic [FINE_BITS-1:0] win_row,
  input  logic                 bg_map_sel,
  input  logic                 win_map_sel,
  input  logic [IDX_W-1:0]     tile_idx,
  output logic [ADDR_W-1:0]    addr
);

  localparam int DATA_W = IDX_W + FINE_BITS + 1;

  logic [MAP_BITS-1:0]  col_m;
  logic [MAP_BITS-1:0]  tx;
  logic [MAP_BITS-1:0]  ty;
  logic [FINE_BITS-1:0] row;
  logic                 sel_hi;
  logic [ADDR_W-1:0]    base;
  logic [ADDR_W-1:0]    map_addr;
  logic [DATA_W-1:0]    data_raw;
  logic [ADDR_W-1:0]    data_addr;

  always_comb begin
    col_m     = MAP_BITS'(col);
    tx        = (layer == LYR_BG) ? (bg_tx0 + col_m) : col_m;
    ty        = (layer == LYR_BG) ? bg_ty : win_ty;
    row       = (layer == LYR_BG) ? bg_row : win_row;
    sel_hi    = (layer == LYR_BG) ? bg_map_sel : win_map_sel;
    base      = sel_hi ? MAP_BASE_HI : MAP_BASE_LO;
    map_addr  = base + ADDR_W'({ty, tx});
    data_raw  = {tile_idx, row, (kind == KIND_HI)};
    data_addr = ADDR_W'(data_raw);
    addr      = (kind == KIND_MAP) ? map_addr : data_addr;
  end

endmodule

// File: rtl/tmap_addr_gen.sv
module tmap_addr_gen
  import tmap_pkg::*;
#(
  parameter int                COORD_W     = 8,
  parameter int                MAP_DIM     = 32,
  parameter int                TILE_PX     = 8,
  parameter int                SCREEN_W    = 160,
  parameter int                WIN_X_OFS   = 7,
  parameter int                ADDR_W      = 13,
  parameter logic [ADDR_W-1:0] MAP_BASE_LO = 13'h1800,
  parameter logic [ADDR_W-1:0] MAP_BASE_HI = 13'h1C00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COORD_W-1:0] line,
  input  logic [COORD_W-1:0] scx,
  input  logic [COORD_W-1:0] scy,
  input  logic [COORD_W-1:0] wx,
  input  logic [COORD_W-1:0] wy,
  input  logic [7:0]         ctrl,
  output logic               rd_req,
  output logic [1:0]         rd_kind,
  output logic               rd_layer,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_ack,
  input  logic [COORD_W-1:0] rd_data
);

  localparam int MAP_BITS  = $clog2(MAP_DIM);
  localparam int FINE_BITS = $clog2(TILE_PX);
  localparam int SPAN      = SCREEN_W + TILE_PX;
  localparam int BG_COLS   = SPAN / TILE_PX + 1;
  localparam int COL_W     = $clog2(BG_COLS + 1);
  localparam int IDX_W     = COORD_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // latched line configuration
  logic [COORD_W-1:0] line_q, scx_q, scy_q, wx_q, wy_q;
  logic [7:0]         ctrl_q;
  logic               load;
  logic               map_ack;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      scx_q  <= '0;
      scy_q  <= '0;
      wx_q   <= '0;
      wy_q   <= '0;
      ctrl_q <= '0;
    end else if (load) begin
      line_q <= line;
      scx_q  <= scx;
      scy_q  <= scy;
      wx_q   <= wx;
      wy_q   <= wy;
      ctrl_q <= ctrl;
    end
  end

  // tile index capture with signed/unsigned remap
  logic [IDX_W-1:0] idx_n, idx_q;
  always_comb begin
    if (!ctrl_q[CTL_IDX_UNSGN] && !rd_data[COORD_W-1]) idx_n = {1'b1, rd_data};
    else                                              idx_n = {1'b0, rd_data};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (map_ack) idx_q <= idx_n;
  end

  logic [MAP_BITS-1:0]  bg_tx0, bg_ty, win_ty;
  logic [FINE_BITS-1:0] bg_row, win_row;
  logic [COL_W-1:0]     win_cols, col;
  logic                 win_on, busy;
  rd_kind_e             kind;
  layer_e               layer;

  tmap_scroll_calc #(
    .COORD_W(COORD_W), .MAP_BITS(MAP_BITS), .FINE_BITS(FINE_BITS),
    .SPAN(SPAN), .WIN_X_OFS(WIN_X_OFS), .COL_W(COL_W)
  ) calc_i (
    .line(line_q), .scx(scx_q), .scy(scy_q), .wx(wx_q), .wy(wy_q),
    .win_en(ctrl_q[CTL_WIN_EN]),
    .bg_tx0(bg_tx0), .bg_ty(bg_ty), .bg_row(bg_row),
    .win_ty(win_ty), .win_row(win_row), .win_cols(win_cols), .win_on(win_on)
  );

  tmap_col_seq #(
    .COL_W(COL_W), .BG_COLS(BG_COLS)
  ) seq_i (
    .clk(clk), .rst_ni(rst_ni), .start(start), .rd_ack(rd_ack),
    .win_on(win_on), .win_cols(win_cols),
    .busy(busy), .kind(kind), .layer(layer), .col(col),
    .load(load), .map_ack(map_ack)
  );

  tmap_addr_mux #(
    .ADDR_W(ADDR_W), .MAP_BITS(MAP_BITS), .FINE_BITS(FINE_BITS),
    .IDX_W(IDX_W), .COL_W(COL_W),
    .MAP_BASE_LO(MAP_BASE_LO), .MAP_BASE_HI(MAP_BASE_HI)
  ) mux_i (
    .kind(kind), .layer(layer), .col(col),
    .bg_tx0(bg_tx0), .bg_ty(bg_ty), .bg_row(bg_row),
    .win_ty(win_ty), .win_row(win_row),
    .bg_map_sel(ctrl_q[CTL_BG_MAP_SEL]), .win_map_sel(ctrl_q[CTL_WIN_MAP_SEL]),
    .tile_idx(idx_q), .addr(rd_addr)
  );

  assign rd_req   = busy;
  assign rd_kind  = kind;
  assign rd_layer = layer;

  // R1: a pending request keeps its address
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && $stable(rd_kind)));

  // R10: the high plane read comes right after the low plane read, one byte above it
  a_r10_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_req && rd_ack && rd_kind == KIND_LO) |=>
      (rd_req && rd_kind == KIND_HI && rd_addr == $past(rd_addr) + ADDR_W'(1)));

  // R4: map reads land in the tile-map region
  a_r4_map_region: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_req && rd_kind == KIND_MAP) |-> (rd_addr >= MAP_BASE_LO));

  // R5: plane reads land below the tile-map region
  a_r5_data_region: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_req && rd_kind != KIND_MAP) |-> (rd_addr < MAP_BASE_LO));

endmodule

// File: tb/tmap_addr_gen_tb.sv
module tmap_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  line, scx, scy, wx, wy, ctrl;
  logic        rd_req;
  logic [1:0]  rd_kind;
  logic        rd_layer;
  logic [12:0] rd_addr;
  logic        rd_ack;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;
  int acc_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tmap_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .line(line), .scx(scx), .scy(scy), .wx(wx), .wy(wy), .ctrl(ctrl),
    .rd_req(rd_req), .rd_kind(rd_kind), .rd_layer(rd_layer), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data)
  );

  // fields: line, scx, scy, wx, wy, ctrl
  localparam logic [47:0] VEC [0:7] = '{
    48'h000000070010,  // unsigned index, low bases, no window
    48'h05F300070008,  // column wrap 31->0, high bg base, signed
    48'h640DC8325A30,  // row wrap by scy, window on from wx=50
    48'h8F00FF008F68,  // scy=255, window at its top line, wx=0, high bases
    48'h0A2010B00020,  // wx=176: window has no columns
    48'h140500AF0470,  // wx=175: exactly one window column
    48'h030000070930,  // line above wy: no window
    48'hFF8101070060   // window row 31 fine row 7, signed
  };

  function automatic logic [7:0] mem_byte(input int a);
    return 8'(a * 37 + (a >> 5));
  endfunction

  task automatic expect_access(input bit lyr, input int knd, input int addr,
                               input string tag, output logic [7:0] d);
    int waitc = 0;
    while (!rd_req && waitc < 64) begin
      @(negedge clk);
      waitc++;
    end
    checks++;
    if (!rd_req || rd_addr != 13'(addr) || rd_kind != 2'(knd) || rd_layer != lyr) begin
      fails++;
      $display("FAIL %s: actual req=%0b addr=%h kind=%0d layer=%0d, expected addr=%h kind=%0d layer=%0d",
               tag, rd_req, rd_addr, rd_kind, rd_layer, 13'(addr), knd, lyr);
    end
    repeat (acc_cnt % 3) @(negedge clk);
    d       = mem_byte(addr);
    rd_data = d;
    rd_ack  = 1'b1;
    @(negedge clk);
    rd_ack  = 1'b0;
    acc_cnt++;
  endtask

  task automatic do_column(input bit lyr, input int maddr, input int row,
                           input bit unsgn, input string tag);
    logic [7:0] d;
    int t;
    expect_access(lyr, 0, maddr, tag, d);
    t = (!unsgn && d < 128) ? int'(d) + 256 : int'(d);
    expect_access(lyr, 1, t * 16 + row * 2, "R5 low plane", d);
    expect_access(lyr, 2, t * 16 + row * 2 + 1, "R5 R10 high plane", d);
  endtask

  task automatic run_line(input logic [47:0] v, input bit glitch);
    int ln, sx, sy, px, py, c;
    int by, wl, base, cols;
    ln = int'(v[47:40]); sx = int'(v[39:32]); sy = int'(v[31:24]);
    px = int'(v[23:16]); py = int'(v[15:8]);  c  = int'(v[7:0]);
    line = v[47:40]; scx = v[39:32]; scy = v[31:24];
    wx = v[23:16];   wy = v[15:8];   ctrl = v[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    by   = (ln + sy) & 255;
    base = c[3] ? 'h1C00 : 'h1800;
    for (int col = 0; col < 22; col++) begin
      do_column(1'b0, base + (by >> 3) * 32 + (((sx >> 3) + col) & 31), by & 7,
                c[4], "R2 R3 R4 R8 bg map");
      if (glitch && col == 0) begin
        // R9: second start with other settings mid-line
        start = 1'b1; line = ~line; scx = ~scx; scy = ~scy; ctrl = ~ctrl;
        @(negedge clk);
        start = 1'b0;
      end
    end
    if (c[5] && ln >= py && px <= 175) begin
      wl   = (ln - py) & 255;
      base = c[6] ? 'h1C00 : 'h1800;
      cols = ((175 - px) >> 3) + 1;
      for (int col = 0; col < cols; col++)
        do_column(1'b1, base + ((wl >> 3) & 31) * 32 + col, wl & 7,
                  c[4], "R6 R7 R8 window map");
    end
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (rd_req !== 1'b0) begin
      fails++;
      $display("FAIL R9 line end: actual rd_req=%0b expected 0 (extra reads)", rd_req);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    start = 0; rd_ack = 0; rd_data = 0;
    line = 0; scx = 0; scy = 0; wx = 0; wy = 0; ctrl = 0;
    do_reset();
    checks++;
    if (rd_req !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: actual rd_req=%0b expected 0", rd_req);
    end

    for (int i = 0; i < 8; i++) run_line(VEC[i], 1'b0);

    // R9: start and input changes during a line are ignored
    run_line(VEC[2], 1'b1);

    // R9: reset in the middle of a line drops the request
    line = 8'd40; ctrl = 8'h10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (rd_req !== 1'b0) begin
      fails++;
      $display("FAIL R9 mid-line reset: actual rd_req=%0b expected 0", rd_req);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_req !== 1'b0) begin
      fails++;
      $display("FAIL R9 after reset release: actual rd_req=%0b expected 0", rd_req);
    end

    // R1 R4 R5: a fresh line after reset still starts at column 0
    run_line(VEC[1], 1'b0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule